// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog timer on a simple word-addressed register bus. A two-stage timebase turns the peripheral clock into counter decrements. A prescaler first counts a programmed number of advance cycles to make one tick. A divider then counts a programmed number of those ticks to make one decrement. The advance source is either every bus clock or a slow reference enable input, chosen by a control bit. A down-counter is armed from a load register and runs only while the enable bit is set.

Software services the watchdog by strobing a load-enable register, so it never has to rewrite the load value. One strobe bit copies the load value into the counter. A second bit restarts the prescaler and the divider. When the counter reaches zero, the block sets a sticky interrupt bit and a raw status bit. If reset is enabled, it also drives a fixed-length reset request pulse to an external reset controller.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, control reads 0, the live count reads all ones, the interrupt bit reads 0, and both `irq` and `rst_req` are low.
- R2: The word index is `bus_addr[5:2]`: 0 control, 1 prescale, 2 divider, 3 load, 4 load-enable, 5 live count, 6 interrupt enable, 7 interrupt, 8 status. Control, prescale, divider, load and interrupt-enable read back the value last written.
- R3: Control bit 0 enables counting, bit 1 enables the reset request, and bit 2 selects the advance source.
- R4: With control bit 2 clear, expiry occurs P·D·L clock edges after the edge that enables counting following a load-enable write of 3. Here P is the prescale value, D the divider value and L the load value, and a prescale or divider value of 0 counts as 1. With prescale N, divider 1 and load 1, expiry therefore occurs N edges after enable.
- R5: Writing 1 to load-enable bit 0 copies the load value into the counter and clears the status bit. Writing 1 to bit 1 restarts the prescaler and divider from zero. The load-enable register always reads 0.
- R6: While control bit 0 is clear, the counter and the timebase hold their values, so writing 0 to control stops the watchdog.
- R7: The interrupt register bit 0 is set on expiry and cleared by writing 1 to it. The output `irq` is high exactly when both the interrupt bit and interrupt-enable bit 0 are set.
- R8: Status bit 0 is set on expiry whatever the interrupt enable holds, and only a counter reload clears it.
- R9: On expiry with control bits 0 and 1 both set, `rst_req` is high for exactly PULSE_LEN (default 16) cycles. With bit 1 clear, `rst_req` stays low.
- R10: With control bit 2 set, the prescaler advances only in cycles where `ref_tick` is high.
- R11: The live count register is read-only, and bus writes to it have no effect.
- R12: After expiry the counter rests at 0, and no further expiry occurs until the counter is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ref_tick | input | 1 | Slow reference enable that qualifies prescaler advance |
| irq | output | 1 | Interrupt, interrupt bit AND enable |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench builds the block with its defaults: 32-bit prescale and count, a 16-bit divider, and a 16-cycle reset pulse. Small prescale, divider and load values keep every expiry within a few dozen cycles. A table of prescale/divider/load triples then measures exact expiry latencies, including the zero-means-one encodings. The all-ones reset count can only be read back, never waited out. Directed cases cover the restart strobe during counting, stopping, the reference-gated source, and clearing the interrupt without re-expiry.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int PS_W      = 32,
  parameter int DIV_W     = 16,
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ref_tick,
  output logic        irq,
  output logic        rst_req
);
  localparam int PL_W = $clog2(PULSE_LEN + 1);

  logic [2:0]       ctrl_q;
  logic [PS_W-1:0]  ps_q, ps_cnt;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             ie_q, int_q, stat_q;
  logic [PL_W-1:0]  pulse_cnt;

  wire [3:0] widx    = bus_addr[5:2];
  wire       wr      = bus_sel & bus_we;
  wire       ld_cnt  = wr && widx == 4'd4 && bus_wdata[0];
  wire       ld_tb   = wr && widx == 4'd4 && bus_wdata[1];

  wire adv      = ctrl_q[0] && (ctrl_q[2] ? ref_tick : 1'b1);
  wire ps_last  = (ps_q == '0) || (ps_cnt >= ps_q - 1'b1);
  wire ptick    = adv && ps_last;
  wire div_last = (div_q == '0) || (div_cnt >= div_q - 1'b1);
  wire dtick    = ptick && div_last;
  wire fire     = dtick && !ld_cnt && cnt_q == CNT_W'(1);

  assign irq     = int_q & ie_q;
  assign rst_req = pulse_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ps_q   <= '0;
      div_q  <= '0;
      load_q <= '1;
      ie_q   <= 1'b0;
    end else if (wr) begin
      case (widx)
        4'd0: ctrl_q <= bus_wdata[2:0];
        4'd1: ps_q   <= bus_wdata[PS_W-1:0];
        4'd2: div_q  <= bus_wdata[DIV_W-1:0];
        4'd3: load_q <= bus_wdata[CNT_W-1:0];
        4'd6: ie_q   <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt  <= '0;
      div_cnt <= '0;
    end else if (ld_tb) begin
      ps_cnt  <= '0;
      div_cnt <= '0;
    end else if (adv) begin
      ps_cnt <= ps_last ? '0 : ps_cnt + 1'b1;
      if (ptick) div_cnt <= div_last ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      stat_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      if (ld_cnt)                    cnt_q <= load_q;
      else if (dtick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (ld_cnt)    stat_q <= 1'b0;
      else if (fire) stat_q <= 1'b1;
      if (fire)                                         int_q <= 1'b1;
      else if (wr && widx == 4'd7 && bus_wdata[0])      int_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pulse_cnt <= '0;
    else if (fire && ctrl_q[1])   pulse_cnt <= PL_W'(PULSE_LEN);
    else if (pulse_cnt != '0)     pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_comb begin
    case (widx)
      4'd0:    bus_rdata = {29'd0, ctrl_q};
      4'd1:    bus_rdata = 32'(ps_q);
      4'd2:    bus_rdata = 32'(div_q);
      4'd3:    bus_rdata = 32'(load_q);
      4'd5:    bus_rdata = 32'(cnt_q);
      4'd6:    bus_rdata = {31'd0, ie_q};
      4'd7:    bus_rdata = {31'd0, int_q};
      4'd8:    bus_rdata = {31'd0, stat_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module wdt_prescaled_chk #(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             ld_cnt,
  input logic             fire,
  input logic [CNT_W-1:0] cnt_q,
  input logic             int_q,
  input logic             stat_q,
  input logic             rst_req
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 0;
    else if (fire)    run <= 0;
    else if (rst_req) run <= run + 1;
  end

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_cnt) |=> $stable(cnt_q));
  assert_never_counts_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cnt |=> (cnt_q <= $past(cnt_q)));
  assert_expiry_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (int_q && stat_q));
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(fire));
  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (run < PULSE_LEN));
endmodule

bind wdt_prescaled wdt_prescaled_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .ld_cnt(ld_cnt), .fire(fire),
  .cnt_q(cnt_q), .int_q(int_q), .stat_q(stat_q), .rst_req(rst_req)
);

// File: tb/wdt_prescaled_bench.sv
module wdt_prescaled_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        ref_tick = 0, irq, rst_req;
  int errors = 0, checks = 0;

  wdt_prescaled u_wdt_prescaled (.*);

  always #4 clk = ~clk;

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: bench hung, got running expected finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [5:0] A_CTRL = 6'h00, A_PS = 6'h04, A_DIV = 6'h08, A_LD = 6'h0C,
    A_LDE = 6'h10, A_CNT = 6'h14, A_IE = 6'h18, A_INT = 6'h1C, A_STAT = 6'h20;

  // prescale, divider, load, expected edges to expiry
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{1, 1, 1, 1}, '{4, 1, 1, 4}, '{3, 2, 2, 12},
    '{0, 3, 2, 6}, '{5, 1, 3, 15}, '{1, 0, 5, 5}};

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_expiry(output int k);
    logic [31:0] s;
    k = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); k++;
      rd(A_STAT, s);
      if (s[0]) return;
    end
    k = -1;
  endtask

  task automatic arm(input int ps, input int dv, input int ld, input logic [31:0] ctl);
    wr(A_CTRL, 0);
    wr(A_PS, ps); wr(A_DIV, dv); wr(A_LD, ld);
    wr(A_INT, 1);
    wr(A_LDE, 3);
    wr(A_CTRL, ctl);
  endtask

  initial begin
    logic [31:0] v, v2;
    int k, hi;
    #20; rst_n = 1;
    @(negedge clk);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 32'hFFFF_FFFF);
    rd(A_INT, v);  chk("R1 int", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", rst_req, 0);

    wr(A_PS, 32'h1234); rd(A_PS, v); chk("R2 prescale readback", v, 32'h1234);
    wr(A_DIV, 7); rd(A_DIV, v); chk("R2 divider readback", v, 7);
    wr(A_CTRL, 6); rd(A_CTRL, v); chk("R3 ctrl readback", v, 6);
    wr(A_LDE, 3); rd(A_LDE, v); chk("R5 load-enable reads 0", v, 0);

    for (int n = 0; n < NV; n++) begin
      arm(VEC[n][0], VEC[n][1], VEC[n][2], 1);
      wait_expiry(k);
      chk("R4 expiry latency", k, VEC[n][3]);
    end

    rd(A_INT, v);  chk("R7 int set on expiry", v, 1);
    chk("R7 irq masked", irq, 0);
    rd(A_STAT, v); chk("R8 status without enable", v, 1);
    chk("R9 no pulse without reset enable", rst_req, 0);
    wr(A_IE, 1); chk("R7 irq enabled", irq, 1);
    wr(A_INT, 1);
    rd(A_INT, v); chk("R7 int cleared", v, 0);
    chk("R7 irq after clear", irq, 0);
    rd(A_STAT, v); chk("R8 status survives clear", v, 1);
    repeat (20) @(negedge clk);
    rd(A_INT, v); chk("R12 no re-expiry", v, 0);
    rd(A_CNT, v); chk("R12 count rests at 0", v, 0);
    wr(A_LDE, 1);
    rd(A_STAT, v); chk("R5 reload clears status", v, 0);
    wr(A_IE, 0);

    arm(1, 1, 10, 1);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_CNT, v);
    repeat (5) @(negedge clk);
    rd(A_CNT, v2); chk("R6 count held when stopped", v2, v);
    wr(A_CNT, 32'h55);
    rd(A_CNT, v2); chk("R11 count write ignored", v2, v);

    arm(4, 1, 3, 1);
    repeat (2) @(negedge clk);
    wr(A_LDE, 3);
    wait_expiry(k); chk("R5 restart strobe latency", k, 12);

    arm(2, 1, 2, 5);
    rd(A_CNT, v);
    repeat (10) @(negedge clk);
    rd(A_CNT, v2); chk("R10 gated by ref_tick low", v2, v);
    wr(A_LDE, 3);
    ref_tick = 1;
    wait_expiry(k); chk("R10 ref_tick high latency", k, 4);
    ref_tick = 0;

    arm(1, 1, 2, 3);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst_req) hi++;
    end
    chk("R9 reset pulse length", hi, 16);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule